// File: doc/BRIEF.md
# PLL Loss-of-Lock Monitor

This block decides whether a phase-locked loop still tracks its reference. It counts edges of the divided feedback clock over a fixed window of 2^WIN_LOG2 reference cycles and takes the absolute difference between that count and the window length as the frequency error. Raising and releasing the alarm are governed by two separate programmable thresholds.

An error above the upper threshold raises loss-of-lock at once. An error below the lower threshold releases it, either directly or after a programmable settling delay in reference cycles. Errors that fall between the two thresholds leave the state where it is, which keeps the status from toggling while the loop is still pulling in.

The state is reported three ways: a live bit, a sticky bit that software clears with a one-cycle pulse, and an active-low pin. The feedback count reaches the reference domain through a Gray-coded synchronizer. Thresholds are expressed in counts per window, so one count corresponds to 1/2^WIN_LOG2 of relative frequency error.

Top module: `pll_lock_watch`

## Requirements
- R1: After reset, `lol_live` is 1, `lol_sticky` is 1 and `lol_n` is 0.
- R2: Once every 2^WIN_LOG2 reference cycles, the frequency error is computed as |feedback edges counted in the window − 2^WIN_LOG2|. The count may be off by ±1 because of synchronization. The ratio between the two clocks must stay below 4.
- R3: A window whose error is strictly greater than `set_thr` sets `lol_live` to 1 on the following cycle.
- R4: With `dly_en` = 0, a window whose error is strictly less than `clr_thr` (and not above `set_thr`) clears `lol_live` on the following cycle. Nothing else clears it in this mode.
- R5: A window whose error is at least `clr_thr` and at most `set_thr` leaves `lol_live` unchanged.
- R6: With `dly_en` = 1, the first window below `clr_thr` while `lol_live` is 1 loads a timer with `dly_cycles`. `lol_live` clears one cycle after that timer has counted down to zero, and not earlier.
- R7: With `dly_en` = 1, a window whose error is at least `clr_thr` while the timer runs cancels the timer. The next window below `clr_thr` reloads it from `dly_cycles`.
- R8: `lol_sticky` becomes 1 on every set event. It returns to 0 only on the cycle after a `sticky_clr` pulse, and it stays 1 when `lol_live` later clears.
- R9: When a set event and `sticky_clr` fall in the same cycle, `lol_sticky` is 1 afterwards.
- R10: `lol_n` is always the inverse of `lol_live`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; runs all logic except the feedback counter |
| fb_clk | input | 1 | Divided feedback clock as it enters the phase detector |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_thr | input | THR_W | Error above which loss-of-lock is raised (counts per window) |
| clr_thr | input | THR_W | Error below which loss-of-lock may be released |
| dly_en | input | 1 | 1 selects the delayed release |
| dly_cycles | input | DLY_W | Settling delay in reference cycles |
| sticky_clr | input | 1 | One-cycle pulse that clears the sticky bit |
| lol_live | output | 1 | Current loss-of-lock state |
| lol_sticky | output | 1 | Latched record of any loss-of-lock event |
| lol_n | output | 1 | Active-low loss-of-lock pin |

## Verification
The feedback clock is run at four periods against a 20 ns reference: equal (error near 0), 19.5 ns (error near 6), 18 ns (error near 28) and 22 ns (error near 23). With thresholds of 4 and 16, the equal case separates release from hold, the 19.5 ns case lies inside the hysteresis band and shows that the state is held from both sides, and the fast and slow cases show that the error is a magnitude in both directions. Moving the thresholds around the 19.5 ns error ties the count to the measured error. Switching to a band error partway through the settling delay separates a timer that restarts from one that keeps running.

// File: rtl/lm_pkg.sv
package lm_pkg;
   typedef enum logic {CLR_IMMEDIATE = 1'b0, CLR_DELAYED = 1'b1} clr_mode_e;

   // counter width that covers up to four windows of feedback edges
   function automatic int unsigned cnt_bits(input int unsigned win_log2);
      return win_log2 + 2;
   endfunction
endpackage

// File: rtl/lm_fb_counter.sv
module lm_fb_counter #(
   parameter int CW = 10
) (
   input  logic          fb_clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt_gray
);
   logic [1:0]    rst_pipe;
   logic [CW-1:0] cnt_bin;
   logic [CW-1:0] cnt_nxt;

   assign cnt_nxt = cnt_bin + 1'b1;

   always_ff @(posedge fb_clk or negedge rst_n) begin
      if (!rst_n) rst_pipe <= '0;
      else        rst_pipe <= {rst_pipe[0], 1'b1};
   end

   always_ff @(posedge fb_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_bin  <= '0;
         cnt_gray <= '0;
      end else if (rst_pipe[1]) begin
         cnt_bin  <= cnt_nxt;
         cnt_gray <= cnt_nxt ^ (cnt_nxt >> 1);
      end
   end
endmodule

// File: rtl/lm_gray_sync.sv
module lm_gray_sync #(
   parameter int CW     = 10,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] gray_in,
   output logic [CW-1:0] bin_out
);
   logic [CW-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lm_gray_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= gray_in;
            else             stg[s] <= stg[s-1];
         end
      end
   endgenerate

   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = CW - 1; i >= 0; i--) begin
         acc        = acc ^ stg[STAGES-1][i];
         bin_out[i] = acc;
      end
   end
endmodule

// File: rtl/lm_window_meter.sv
module lm_window_meter #(
   parameter int WIN_LOG2 = 8,
   parameter int CW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] fb_bin,
   output logic          err_vld,
   output logic [CW-1:0] err
);
   localparam logic [CW-1:0] WIN = CW'(1) << WIN_LOG2;

   logic [WIN_LOG2-1:0] tick;
   logic                primed;
   logic [CW-1:0]       prev;
   logic [CW-1:0]       delta;
   logic [CW-1:0]       mag;

   assign delta = fb_bin - prev;
   assign mag   = (delta >= WIN) ? (delta - WIN) : (WIN - delta);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick    <= '0;
         primed  <= 1'b0;
         prev    <= '0;
         err_vld <= 1'b0;
         err     <= '0;
      end else begin
         tick    <= tick + 1'b1;
         err_vld <= 1'b0;
         if (tick == '1) begin
            prev   <= fb_bin;
            primed <= 1'b1;
            if (primed) begin
               err_vld <= 1'b1;
               err     <= mag;
            end
         end
      end
   end
endmodule

// File: rtl/lm_lock_core.sv
module lm_lock_core
   import lm_pkg::*;
#(
   parameter int CW        = 10,
   parameter int THR_W     = 16,
   parameter int DLY_W     = 16,
   parameter bit USE_TIMER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_vld,
   input  logic [CW-1:0]    err,
   input  logic [THR_W-1:0] set_thr,
   input  logic [THR_W-1:0] clr_thr,
   input  logic             dly_en,
   input  logic [DLY_W-1:0] dly_cycles,
   input  logic             sticky_clr,
   output logic             lol,
   output logic             sticky
);
   logic [THR_W-1:0] err_x;
   logic             set_evt, good, bad, clr_evt;
   clr_mode_e        mode;

   assign err_x   = THR_W'(err);
   assign set_evt = err_vld && (err_x > set_thr);
   assign good    = err_vld && (err_x < clr_thr);
   assign bad     = err_vld && !(err_x < clr_thr);
   assign mode    = dly_en ? CLR_DELAYED : CLR_IMMEDIATE;

   generate
      if (USE_TIMER) begin : g_timer
         logic             armed;
         logic [DLY_W-1:0] left;
         logic             expire;

         assign expire  = armed && (left == '0) && !bad;
         assign clr_evt = (mode == CLR_DELAYED) ? expire : good;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed <= 1'b0;
               left  <= '0;
            end else if (!lol || set_evt || bad || clr_evt || mode == CLR_IMMEDIATE) begin
               armed <= 1'b0;
            end else if (good && !armed) begin
               armed <= 1'b1;
               left  <= dly_cycles;
            end else if (armed && left != '0) begin
               left  <= left - 1'b1;
            end
         end
      end else begin : g_no_timer
         logic unused_dly;
         assign unused_dly = ^{dly_cycles, bad, mode};
         assign clr_evt    = good;
      end
   endgenerate

   // set side of the latch dominates the clear side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lol <= 1'b1;
      else if (set_evt) lol <= 1'b1;
      else if (clr_evt) lol <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sticky <= 1'b1;
      else if (set_evt)    sticky <= 1'b1;
      else if (sticky_clr) sticky <= 1'b0;
   end
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
   import lm_pkg::*;
#(
   parameter int WIN_LOG2    = 8,
   parameter int THR_W       = 16,
   parameter int DLY_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_TIMER   = 1'b1
) (
   input  logic             ref_clk,
   input  logic             fb_clk,
   input  logic             rst_n,
   input  logic [THR_W-1:0] set_thr,
   input  logic [THR_W-1:0] clr_thr,
   input  logic             dly_en,
   input  logic [DLY_W-1:0] dly_cycles,
   input  logic             sticky_clr,
   output logic             lol_live,
   output logic             lol_sticky,
   output logic             lol_n
);
   localparam int CW = cnt_bits(WIN_LOG2);

   generate
      if (WIN_LOG2 < 2 || WIN_LOG2 > 24) begin : g_bad_win
         $error("WIN_LOG2 out of range");
      end
      if (THR_W < CW) begin : g_bad_thr
         $error("THR_W narrower than the error count");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("DLY_W must be positive");
      end
   endgenerate

   logic [CW-1:0] fb_gray;
   logic [CW-1:0] fb_bin;
   logic          err_vld;
   logic [CW-1:0] err;

   lm_fb_counter #(.CW(CW)) u_fb_cnt (
      .fb_clk   (fb_clk),
      .rst_n    (rst_n),
      .cnt_gray (fb_gray)
   );

   lm_gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .gray_in (fb_gray),
      .bin_out (fb_bin)
   );

   lm_window_meter #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_meter (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .fb_bin  (fb_bin),
      .err_vld (err_vld),
      .err     (err)
   );

   lm_lock_core #(.CW(CW), .THR_W(THR_W), .DLY_W(DLY_W), .USE_TIMER(USE_TIMER)) u_core (
      .clk        (ref_clk),
      .rst_n      (rst_n),
      .err_vld    (err_vld),
      .err        (err),
      .set_thr    (set_thr),
      .clr_thr    (clr_thr),
      .dly_en     (dly_en),
      .dly_cycles (dly_cycles),
      .sticky_clr (sticky_clr),
      .lol        (lol_live),
      .sticky     (lol_sticky)
   );

   assign lol_n = ~lol_live;
endmodule

// File: rtl/lm_lock_watch_chk.sv
module lm_lock_watch_chk #(
   parameter int CW    = 10,
   parameter int THR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             err_vld,
   input logic [CW-1:0]    err,
   input logic [THR_W-1:0] set_thr,
   input logic [THR_W-1:0] clr_thr,
   input logic             dly_en,
   input logic             sticky_clr,
   input logic             lol_live,
   input logic             lol_sticky
);
   logic [THR_W-1:0] ex;
   assign ex = THR_W'(err);

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld && ex > set_thr |=> lol_live && lol_sticky);            // R3
   AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld && ex >= clr_thr && ex <= set_thr |=> lol_live == $past(lol_live)); // R5
   AST_FAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld && ex < clr_thr && ex <= set_thr && !dly_en |=> !lol_live); // R4
   AST_RELEASE_ONLY_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      lol_live && !err_vld && !dly_en |=> lol_live);                   // R4
   AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      lol_sticky && !sticky_clr |=> lol_sticky);                       // R8
endmodule

bind pll_lock_watch lm_lock_watch_chk #(.CW(CW), .THR_W(THR_W)) u_chk (
   .clk        (ref_clk),
   .rst_n      (rst_n),
   .err_vld    (err_vld),
   .err        (err),
   .set_thr    (set_thr),
   .clr_thr    (clr_thr),
   .dly_en     (dly_en),
   .sticky_clr (sticky_clr),
   .lol_live   (lol_live),
   .lol_sticky (lol_sticky)
);

// File: tb/test_pll_lock_watch.sv
`timescale 1ns/1ps
module test_pll_lock_watch;
   localparam int THR_W = 16;
   localparam int DLY_W = 16;
   localparam int WIN   = 256;
   localparam int NVEC  = 7;

   // feedback half period in ps, expected live bit, requirement
   localparam int  VEC_PS  [NVEC] = '{10000, 9750, 9000, 9750, 10000, 11000, 10000};
   localparam bit  VEC_EXP [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam string VEC_REQ [NVEC] = '{"R4", "R5", "R3", "R5", "R4", "R3", "R4"};

   logic             clk = 1'b0;
   logic             fb_clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [THR_W-1:0] set_thr = 16'd16;
   logic [THR_W-1:0] clr_thr = 16'd4;
   logic             dly_en = 1'b0;
   logic [DLY_W-1:0] dly_cycles = '0;
   logic             sticky_clr = 1'b0;
   logic             lol_live, lol_sticky, lol_n;
   int               fb_half_ps = 10000;
   int               total = 0;
   int               bad = 0;

   always #10 clk = ~clk;
   initial forever begin
      #(real'(fb_half_ps) / 1000.0);
      fb_clk = ~fb_clk;
   end

   pll_lock_watch #(.WIN_LOG2(8), .THR_W(THR_W), .DLY_W(DLY_W)) i_pll_lock_watch (
      .ref_clk    (clk),
      .fb_clk     (fb_clk),
      .rst_n      (rst_n),
      .set_thr    (set_thr),
      .clr_thr    (clr_thr),
      .dly_en     (dly_en),
      .dly_cycles (dly_cycles),
      .sticky_clr (sticky_clr),
      .lol_live   (lol_live),
      .lol_sticky (lol_sticky),
      .lol_n      (lol_n)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cycles(5);
      rst_n = 1'b1;
      cycles(2);
      check("R1", "live after reset", lol_live, 1'b1);
      check("R1", "sticky after reset", lol_sticky, 1'b1);
      check("R1", "pin after reset", lol_n, 1'b0);

      // table walk, immediate release, thresholds 4 / 16
      for (int i = 0; i < NVEC; i++) begin
         fb_half_ps = VEC_PS[i];
         cycles(4 * WIN);
         check(VEC_REQ[i], "live in table", lol_live, VEC_EXP[i]);
         check("R10", "pin in table", lol_n, ~VEC_EXP[i]);
      end

      // R8: sticky clears on a pulse
      sticky_clr = 1'b1;
      cycles(1);
      sticky_clr = 1'b0;
      cycles(1);
      check("R8", "sticky after clear pulse", lol_sticky, 1'b0);
      check("R8", "live untouched by clear pulse", lol_live, 1'b0);

      // R2: error near 6 counts sits above 4 and below 8
      set_thr = 16'd4;
      fb_half_ps = 9750;
      cycles(4 * WIN);
      check("R2", "error above 4 raises", lol_live, 1'b1);
      set_thr = 16'd16;
      clr_thr = 16'd8;
      cycles(4 * WIN);
      check("R2", "error below 8 releases", lol_live, 1'b0);
      clr_thr = 16'd4;
      fb_half_ps = 10000;
      cycles(2 * WIN);

      // R9: set event while clear is held
      sticky_clr = 1'b1;
      cycles(2);
      fb_half_ps = 9000;
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         if (lol_live) break;
      end
      check("R9", "live raised", lol_live, 1'b1);
      check("R9", "sticky with simultaneous clear", lol_sticky, 1'b1);
      sticky_clr = 1'b0;

      // R8: sticky survives the release of live
      fb_half_ps = 10000;
      cycles(4 * WIN);
      check("R8", "live released", lol_live, 1'b0);
      check("R8", "sticky kept", lol_sticky, 1'b1);

      // R6: delayed release
      dly_en = 1'b1;
      dly_cycles = 16'd1500;
      fb_half_ps = 9000;
      cycles(3 * WIN);
      fb_half_ps = 10000;
      cycles(3 * WIN);
      check("R6", "still held during delay", lol_live, 1'b1);
      cycles(2048);
      check("R6", "released after delay", lol_live, 1'b0);

      // R7: band error during the delay restarts the timer
      fb_half_ps = 9000;
      cycles(3 * WIN);
      fb_half_ps = 10000;
      cycles(2 * WIN);
      fb_half_ps = 9750;
      cycles(6 * WIN);
      check("R7", "held after timer cancel", lol_live, 1'b1);
      fb_half_ps = 10000;
      cycles(10 * WIN);
      check("R7", "released after reload", lol_live, 1'b0);
      check("R10", "pin after reload", lol_n, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule